// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block keeps an asynchronous DRAM's contents alive and brings the device up after reset. Once reset is released it keeps every strobe inactive for a programmable power-up pause. It then runs a fixed burst of CAS-before-RAS refresh cycles on its own, and only after that burst does it raise `ready_o`. From then on a free-running interval timer owes one refresh per row slot: the refresh period divided by the number of rows. Owed refreshes accumulate in a saturating backlog.

The access sequencer owns the DRAM bus in normal operation. When a refresh is owed and the scheduler is idle, the scheduler raises `req_o`. The sequencer answers with `gnt_i` at a closed-row boundary, and the scheduler then drives RAS, CAS, WE and the row address until `own_o` falls. Per grant, the sequencer picks one of three refresh styles:
- CAS-before-RAS, which uses the device's internal row counter.
- RAS-only, which presents a row from the scheduler's own wrapping row counter.
- Hidden, for the case where CAS is already low after a read; RAS is precharged and cycled again while CAS stays low.

All timing limits are counts of clock cycles derived from parameters.

Top module: `dram_refresh_sched`

## Requirements
- R1: For PAUSE_US*CLK_MHZ cycles after reset release, `ras_n_o` and `cas_n_o` stay high and `ready_o`, `req_o` and `own_o` stay low.
- R2: After the pause, exactly INIT_CYCLES CAS-before-RAS refreshes run without any grant, whatever `ras_only_i` and `hidden_i` are. `ready_o` then rises and stays high.
- R3: In a CAS-before-RAS refresh, CAS falls exactly CSR_CYC cycles before RAS falls and is held low for the whole RAS-low time. `we_n_o` is high throughout.
- R4: Every refresh holds `ras_n_o` low for exactly RAS_CYC cycles. Consecutive RAS-low periods are separated by at least RP_CYC cycles of RAS high.
- R5: Counting starts when `ready_o` rises. After every INTERVAL = REF_PERIOD_US*CLK_MHZ/ROWS cycles one refresh is added to `pend_o`.
- R6: `pend_o` saturates at MAX_BACKLOG, and further owed refreshes are dropped. If an owed refresh and a completed refresh coincide, `pend_o` is unchanged.
- R7: `req_o` is high exactly when `ready_o` is high, `pend_o` is nonzero and the scheduler is idle. A `gnt_i` sampled with `req_o` high starts a refresh on that edge. `own_o` is high until the refresh ends, and `pend_o` drops by one on that edge.
- R8: With `ras_only_i` high at grant, CAS stays high and `addr_o` carries the row for one cycle before RAS falls and for the whole RAS-low time. The row starts at 0 and advances by one, modulo ROWS, after each such refresh.
- R9: With `hidden_i` high at grant, CAS is low from the first owned cycle, RAS stays high for RP_CYC cycles, and RAS then falls while CAS remains low. `hidden_i` takes priority over `ras_only_i`.
- R10: A `gnt_i` that arrives while `req_o` is low has no effect: `own_o`, the strobes and `pend_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_only_i | input | 1 | Selects RAS-only refresh for the granted cycle |
| hidden_i | input | 1 | Selects hidden refresh (CAS already low) for the granted cycle |
| gnt_i | input | 1 | Bus grant from the access sequencer |
| req_o | output | 1 | Refresh request to the access sequencer |
| own_o | output | 1 | Scheduler is driving the DRAM strobes |
| ready_o | output | 1 | Power-up pause and initialization burst complete |
| pend_o | output | $clog2(MAX_BACKLOG+1) | Count of owed refreshes |
| ras_n_o | output | 1 | Row address strobe, active low |
| cas_n_o | output | 1 | Column address strobe, active low |
| we_n_o | output | 1 | Write enable, active low (held high) |
| addr_o | output | $clog2(ROWS) | Row address for RAS-only refresh |

## Verification
The bench checks the edges of the initialization: a first RAS fall inside the pause, a burst one cycle short or long, and a burst that obeys `ras_only_i` would each surface as a mismatch against the expected strobe sequence. It runs the backlog into saturation and then serves it. An off-by-one interval, a wrapping counter or a lost decrement shows up as a `pend_o` mismatch against a cycle-exact model. It walks the RAS-only row counter across its wrap, where a wrong modulus gives a wrong address. It measures how long CAS leads RAS for normal and hidden refreshes, so swapped lead lengths or a released CAS are caught. A stray grant while no request is pending must leave the bus untouched.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [1:0] {REF_CBR, REF_ROR, REF_HID} ref_kind_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_LEAD, SQ_STROBE, SQ_PRECH} seq_st_e;
  typedef enum logic [1:0] {PH_PAUSE, PH_INIT, PH_RUN} phase_e;
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int INTERVAL    = 3906,
  parameter int MAX_BACKLOG = 8,
  localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1,
  localparam int PW = $clog2(MAX_BACKLOG + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          served_i,
  output logic [PW-1:0] pend_o
);
  logic [TW-1:0] t_q;
  logic          tick;

  assign tick = en_i && (t_q == TW'(INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   t_q <= '0;
    else if (en_i) t_q <= tick ? '0 : t_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else begin
      unique case ({tick, served_i})
        2'b10:   if (pend_o < PW'(MAX_BACKLOG)) pend_o <= pend_o + 1'b1;
        2'b01:   if (pend_o != '0) pend_o <= pend_o - 1'b1;
        default: pend_o <= pend_o;
      endcase
    end
  end

  p_sat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o <= PW'(MAX_BACKLOG));
  p_owed_inc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !served_i && pend_o < PW'(MAX_BACKLOG)) |=> pend_o == $past(pend_o) + 1'b1);
  p_served_dec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (served_i && !tick && pend_o != '0) |=> pend_o == $past(pend_o) - 1'b1);
  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(pend_o));
endmodule

// File: rtl/ref_init_seq.sv
module ref_init_seq
  import dram_ref_pkg::*;
#(
  parameter int PAUSE_CYC   = 50000,
  parameter int INIT_CYCLES = 8,
  localparam int PCW = (PAUSE_CYC > 1) ? $clog2(PAUSE_CYC) : 1,
  localparam int ICW = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic seq_idle_i,
  input  logic seq_done_i,
  output logic start_o,
  output logic busy_o,
  output logic ready_o
);
  phase_e         ph_q;
  logic [PCW-1:0] pcnt_q;
  logic [ICW-1:0] icnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_PAUSE;
      pcnt_q <= '0;
      icnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_PAUSE: begin
          if (pcnt_q == PCW'(PAUSE_CYC - 1)) ph_q <= PH_INIT;
          else pcnt_q <= pcnt_q + 1'b1;
        end
        PH_INIT: begin
          if (seq_done_i) begin
            if (icnt_q == ICW'(INIT_CYCLES - 1)) ph_q <= PH_RUN;
            else icnt_q <= icnt_q + 1'b1;
          end
        end
        default: ph_q <= PH_RUN;
      endcase
    end
  end

  assign start_o = (ph_q == PH_INIT) && seq_idle_i;
  assign busy_o  = (ph_q == PH_INIT);
  assign ready_o = (ph_q == PH_RUN);

  p_ready_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  p_no_start_pause_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !busy_o) |=> !$past(start_o));
endmodule

// File: rtl/ref_row_ptr.sv
module ref_row_ptr #(
  parameter int ROWS = 4096,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [RW-1:0] row_o
);
  generate
    if ((1 << RW) == ROWS) begin : g_pow2
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    row_o <= '0;
        else if (adv_i) row_o <= row_o + 1'b1;
      end
    end else begin : g_mod
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    row_o <= '0;
        else if (adv_i) row_o <= (row_o == RW'(ROWS - 1)) ? '0 : row_o + 1'b1;
      end
    end
  endgenerate

  p_row_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_o <= RW'(ROWS - 1));
  p_row_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(row_o));
endmodule

// File: rtl/ref_strobe_seq.sv
module ref_strobe_seq
  import dram_ref_pkg::*;
#(
  parameter int CSR_CYC = 2,
  parameter int RAS_CYC = 12,
  parameter int RP_CYC  = 8,
  parameter int ROW_W   = 12,
  localparam int MAXD = (RAS_CYC > RP_CYC) ? ((RAS_CYC > CSR_CYC) ? RAS_CYC : CSR_CYC)
                                           : ((RP_CYC > CSR_CYC) ? RP_CYC : CSR_CYC),
  localparam int CW = $clog2(MAXD + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  ref_kind_e        kind_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic [ROW_W-1:0] addr_o,
  output logic             idle_o,
  output logic             done_o,
  output logic             row_used_o
);
  seq_st_e          st_q;
  ref_kind_e        kind_q;
  logic [CW-1:0]    cnt_q;
  logic [ROW_W-1:0] row_q;
  logic [CW-1:0]    lead_len;

  always_comb begin
    unique case (kind_i)
      REF_HID: lead_len = CW'(RP_CYC - 1);
      REF_ROR: lead_len = '0;
      default: lead_len = CW'(CSR_CYC - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_IDLE;
      kind_q <= REF_CBR;
      cnt_q  <= '0;
      row_q  <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: if (start_i) begin
          st_q   <= SQ_LEAD;
          kind_q <= kind_i;
          row_q  <= row_i;
          cnt_q  <= lead_len;
        end
        SQ_LEAD: begin
          if (cnt_q == '0) begin
            st_q  <= SQ_STROBE;
            cnt_q <= CW'(RAS_CYC - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        SQ_STROBE: begin
          if (cnt_q == '0) begin
            st_q  <= SQ_PRECH;
            cnt_q <= CW'(RP_CYC - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        default: begin
          if (cnt_q == '0) st_q <= SQ_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
      endcase
    end
  end

  assign idle_o     = (st_q == SQ_IDLE);
  assign done_o     = (st_q == SQ_PRECH) && (cnt_q == '0);
  assign row_used_o = done_o && (kind_q == REF_ROR);
  assign ras_n_o    = (st_q != SQ_STROBE);
  assign cas_n_o    = !((kind_q != REF_ROR) && (st_q == SQ_LEAD || st_q == SQ_STROBE));
  // WE stays high so a CAS-first cycle never selects the test mode
  assign we_n_o     = 1'b1;
  assign addr_o     = ((kind_q == REF_ROR) && (st_q == SQ_LEAD || st_q == SQ_STROBE)) ? row_q : '0;

  // run-length checkers
  logic [CW:0] lo_run, hi_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_run <= '0;
      hi_run <= (CW+1)'(RP_CYC);
    end else begin
      lo_run <= ras_n_o ? '0 : lo_run + 1'b1;
      if (!ras_n_o) hi_run <= '0;
      else if (hi_run < (CW+1)'(RP_CYC)) hi_run <= hi_run + 1'b1;
    end
  end

  p_ras_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_n_o && $past(!ras_n_o)) |-> lo_run == (CW+1)'(RAS_CYC));
  p_precharge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o && $past(ras_n_o)) |-> hi_run >= (CW+1)'(RP_CYC));
  p_cas_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o && $past(!ras_n_o)) |-> $stable(cas_n_o));
  p_cas_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && !cas_n_o) |-> $past(!cas_n_o));
  p_ror_cas_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && cas_n_o) |-> ($past(cas_n_o) && $stable(addr_o)));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int CLK_MHZ       = 250,
  parameter int PAUSE_US      = 200,
  parameter int REF_PERIOD_US = 64000,
  parameter int ROWS          = 4096,
  parameter int INIT_CYCLES   = 8,
  parameter int MAX_BACKLOG   = 8,
  parameter int CSR_CYC       = 2,
  parameter int RAS_CYC       = 12,
  parameter int RP_CYC        = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             ras_only_i,
  input  logic                             hidden_i,
  input  logic                             gnt_i,
  output logic                             req_o,
  output logic                             own_o,
  output logic                             ready_o,
  output logic [$clog2(MAX_BACKLOG+1)-1:0] pend_o,
  output logic                             ras_n_o,
  output logic                             cas_n_o,
  output logic                             we_n_o,
  output logic [$clog2(ROWS)-1:0]          addr_o
);
  localparam int PAUSE_CYC = PAUSE_US * CLK_MHZ;
  localparam int INTERVAL  = REF_PERIOD_US * CLK_MHZ / ROWS;
  localparam int ROW_W     = $clog2(ROWS);

  logic      seq_idle, seq_done, row_used, init_start, init_busy, run_start, start;
  ref_kind_e kind_sel;
  logic [ROW_W-1:0] row;

  assign req_o     = ready_o && (pend_o != '0) && seq_idle;
  assign run_start = req_o && gnt_i;
  assign start     = init_start || run_start;
  assign own_o     = !seq_idle;

  always_comb begin
    if (init_start)      kind_sel = REF_CBR;
    else if (hidden_i)   kind_sel = REF_HID;
    else if (ras_only_i) kind_sel = REF_ROR;
    else                 kind_sel = REF_CBR;
  end

  ref_init_seq #(.PAUSE_CYC(PAUSE_CYC), .INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk_i(clk_i), .rst_ni(rst_ni), .seq_idle_i(seq_idle), .seq_done_i(seq_done),
    .start_o(init_start), .busy_o(init_busy), .ready_o(ready_o));

  ref_interval_timer #(.INTERVAL(INTERVAL), .MAX_BACKLOG(MAX_BACKLOG)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(ready_o), .served_i(seq_done && ready_o),
    .pend_o(pend_o));

  ref_row_ptr #(.ROWS(ROWS)) u_row (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(row_used), .row_o(row));

  ref_strobe_seq #(.CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC), .ROW_W(ROW_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .kind_i(kind_sel), .row_i(row),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o), .addr_o(addr_o),
    .idle_o(seq_idle), .done_o(seq_done), .row_used_o(row_used));

  p_quiet_pause_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !init_busy) |-> (ras_n_o && cas_n_o && !own_o));
  p_grant_starts_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && gnt_i) |=> (own_o && !req_o));
  p_stray_grant_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !req_o && !own_o && gnt_i) |=> !own_o);
  p_hidden_lead_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && gnt_i && hidden_i) |=> (!cas_n_o && ras_n_o));
endmodule

// File: tb/dram_refresh_sched_tb_top.sv
module dram_refresh_sched_tb_top;
  localparam int CLK_MHZ = 250, PAUSE_US = 2, REF_PERIOD_US = 32, ROWS = 16;
  localparam int INIT_CYCLES = 8, MAX_BACKLOG = 4, CSR_CYC = 2, RAS_CYC = 4, RP_CYC = 3;
  localparam int PAUSE_CYC = PAUSE_US * CLK_MHZ;
  localparam int INTERVAL  = REF_PERIOD_US * CLK_MHZ / ROWS;
  localparam int PW = $clog2(MAX_BACKLOG + 1);
  localparam int RW = $clog2(ROWS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_only = 1'b1, hidden = 1'b1, gnt = 1'b0;
  logic req, own, ready, ras_n, cas_n, we_n;
  logic [PW-1:0] pend;
  logic [RW-1:0] addr;

  always #2 clk = ~clk;

  dram_refresh_sched #(.CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .REF_PERIOD_US(REF_PERIOD_US),
    .ROWS(ROWS), .INIT_CYCLES(INIT_CYCLES), .MAX_BACKLOG(MAX_BACKLOG), .CSR_CYC(CSR_CYC),
    .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ras_only_i(ras_only), .hidden_i(hidden), .gnt_i(gnt),
    .req_o(req), .own_o(own), .ready_o(ready), .pend_o(pend), .ras_n_o(ras_n),
    .cas_n_o(cas_n), .we_n_o(we_n), .addr_o(addr));

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  int exp_lead[$];
  int exp_addr[$];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  // ---------------- monitor / scoreboard ----------------
  int  cyc = 0, rc = 0, falls = 0, first_fall = -1;
  int  lead_run = 0, lo_run = 0, hi_run = 0;
  bit  seen_rise = 0;
  int  pend_m = 0;
  logic ras_p = 1, cas_p = 1, own_p = 0, ready_p = 0, req_p = 0;
  logic [PW-1:0] pend_p = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0;
    end else begin
      bit tick, dec, req_e;
      int pm_old;
      cyc++;
      // backlog model (R5, R6, R7)
      pm_old = pend_m;
      tick = 0;
      if (ready_p) begin
        rc++;
        tick = (rc % INTERVAL == 0);
      end
      dec = own_p && !own && ready_p;
      if (tick && !dec && pend_m < MAX_BACKLOG) pend_m++;
      else if (dec && !tick && pend_m > 0) pend_m--;
      if (pend_m != pm_old || pend != pend_p)
        chk(int'(pend) == pend_m, "R5/R6 pend", int'(pend), pend_m);
      req_e = ready && (pend_m > 0) && !own;
      if (req_e != req_p || req != req_p)
        chk(req == req_e, "R7 req", int'(req), int'(req_e));
      // strobe decoding
      if (ras_p && !ras_n) begin
        falls++;
        if (first_fall < 0) first_fall = cyc;
        if (seen_rise) chk(hi_run >= RP_CYC, "R4 precharge", hi_run, RP_CYC);
        chk(we_n == 1'b1, "R3 we high", int'(we_n), 1);
        if (exp_lead.size() == 0) begin
          chk(0, "R10 unexpected refresh", falls, 0);
        end else begin
          int el, ea;
          el = exp_lead.pop_front();
          ea = exp_addr.pop_front();
          chk(lead_run == el, "R3/R8/R9 cas lead", lead_run, el);
          chk(int'(addr) == ea, "R8 row addr", int'(addr), ea);
        end
      end
      if (!ras_p && !ras_n && cas_n != cas_p)
        chk(0, "R3 cas moved while ras low", int'(cas_n), int'(cas_p));
      if (!ras_p && ras_n) begin
        seen_rise = 1;
        chk(lo_run == RAS_CYC, "R4 ras width", lo_run, RAS_CYC);
      end
      if (!ras_n) begin lo_run++; hi_run = 0; end
      else begin hi_run++; lo_run = 0; end
      lead_run = (ras_n && !cas_n) ? lead_run + 1 : 0;
      ras_p = ras_n; cas_p = cas_n; own_p = own; ready_p = ready; req_p = req; pend_p = pend;
    end
  end

  // ---------------- driver ----------------
  int row_m = 0;
  task automatic grant(input int kind); // 0 CBR, 1 ROR, 2 hidden
    do @(negedge clk); while (!req);
    ras_only = (kind == 1);
    hidden   = (kind == 2);
    exp_lead.push_back(kind == 1 ? 0 : (kind == 2 ? RP_CYC : CSR_CYC));
    exp_addr.push_back(kind == 1 ? row_m : 0);
    if (kind == 1) row_m = (row_m + 1) % ROWS;
    gnt = 1'b1;
    @(negedge clk);
    gnt = 1'b0;
    chk(own == 1'b1, "R7 own after grant", int'(own), 1);
    if (kind == 2) chk(cas_n == 1'b0 && ras_n == 1'b1, "R9 hidden first cycle", int'(cas_n), 0);
    while (own) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < INIT_CYCLES; i++) begin
      exp_lead.push_back(CSR_CYC);
      exp_addr.push_back(0);
    end
    repeat (4) @(negedge clk);
    chk(ras_n && cas_n && !ready && !req, "R1 reset state", int'(ready), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ras_n && cas_n && !ready && !req && !own, "R1 early pause", int'(ras_n), 1);
    repeat (PAUSE_CYC - 6) @(negedge clk);
    chk(ras_n && cas_n && !ready && !own, "R1 late pause", int'(cas_n), 1);
    while (!ready) @(negedge clk);
    chk(first_fall >= PAUSE_CYC, "R1 first refresh after pause", first_fall, PAUSE_CYC);
    chk(falls == INIT_CYCLES, "R2 init burst length", falls, INIT_CYCLES);
    ras_only = 1'b0;
    hidden   = 1'b0;
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R2 ready stays", int'(ready), 1);
    // R10: stray grant with no request
    chk(req == 1'b0, "R10 no request yet", int'(req), 0);
    gnt = 1'b1;
    @(negedge clk);
    gnt = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(own == 1'b0 && ras_n && cas_n, "R10 grant ignored", int'(own), 0);
    end
    chk(int'(pend) == 0, "R10 pend untouched", int'(pend), 0);
    // R5 interval edges
    while (rc < INTERVAL - 3) @(negedge clk);
    chk(int'(pend) == 0, "R5 before first interval", int'(pend), 0);
    while (rc < INTERVAL + 3) @(negedge clk);
    chk(int'(pend) == 1, "R5 after first interval", int'(pend), 1);
    // R6 saturation
    while (rc < 6 * INTERVAL + 5) @(negedge clk);
    chk(int'(pend) == MAX_BACKLOG, "R6 saturated", int'(pend), MAX_BACKLOG);
    chk(req == 1'b1, "R7 request with backlog", int'(req), 1);
    grant(0);
    chk(int'(pend) == MAX_BACKLOG - 1, "R7 served decrement", int'(pend), MAX_BACKLOG - 1);
    grant(2);
    for (int i = 0; i <= ROWS; i++) grant(1);
    repeat (20) @(negedge clk);
    chk(exp_lead.size() == 0, "R8 all expected refreshes seen", exp_lead.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule